// File: doc/BRIEF.md
# FM Operator Attenuation Envelope

This block produces the attenuation envelope of a single FM synthesis operator. It uses five states. A rising key input starts an attack toward zero attenuation. A first decay then runs down to a programmable sustain threshold. A second decay follows, and a release begins when the key drops. Each state takes its own 5-bit rate. That rate is doubled and then raised by a key-scale offset taken from the channel key code.

A free-running prescaler divides the clock by 64 and then by 3 to make the envelope tick. A global tick counter chooses which ticks are allowed to change the attenuation at lower rates. The output is the 10-bit attenuation plus the operator's total level scaled by eight, saturated at full scale. The block stores the key level it saw on the previous cycle, so it acts only on key edges.

Top module: `fm_env_gen`

## Requirements
- R1: After reset, state_o is 0 (off) and level_o is 1023.
- R2: A rising key_i moves state_o to 4 (attack) on the next clock. Holding key_i high never restarts the envelope.
- R3: A falling key_i moves any state other than 0 to 1 (release) on the next clock, including a release from attack. A low key_i while off has no effect.
- R4: The effective rate is 0 when the selected rate input is 0, and a rate of 0 freezes the attenuation. Otherwise the effective rate is min(63, 2*rate + (kcode_i >> (3 - ksr_i))). Attack uses atk_rate_i, state 3 uses dec1_rate_i, state 2 uses dec2_rate_i, and state 1 uses rel_rate_i.
- R5: An envelope tick occurs every 192 clocks. Let E be the effective rate and H = E/4. Below 44, an update happens only on ticks where the low (11 - H) bits of the tick count are zero. At 44 and above, every tick updates. The step is 1 below 48 and 2^(H-11) from 48 up.
- R6: In attack, an effective rate of 62 or more sets the attenuation to 0 at once. Otherwise each update subtracts ((a >> 4) + 1) * step, with a floor of 0.
- R7: Attack at attenuation 0 moves to state 3 (decay) on the next clock.
- R8: Decay adds the step on each update. It moves to state 2 (sustain) once the attenuation reaches the threshold sus_lvl_i*32. A sus_lvl_i of 15 gives a threshold of 1023.
- R9: Sustain adds the step on each update, saturates at 1023 and stays in state 2.
- R10: Release adds the step on each update and moves to state 0 when the attenuation is 1023. State 0 holds 1023.
- R11: level_o = min(1023, attenuation + tot_lvl_i*8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_i | input | 1 | Key level; its edges start attack and release |
| atk_rate_i | input | 5 | Attack rate |
| dec1_rate_i | input | 5 | First decay rate |
| dec2_rate_i | input | 5 | Second decay (sustain) rate |
| rel_rate_i | input | 5 | Release rate |
| sus_lvl_i | input | 4 | Sustain threshold in steps of 32 |
| tot_lvl_i | input | 7 | Total level, added as value*8 |
| ksr_i | input | 2 | Key-scale setting |
| kcode_i | input | 5 | Channel key code |
| level_o | output | 10 | Attenuation plus total level, saturated |
| state_o | output | 3 | Envelope state: 4 attack, 3 decay, 2 sustain, 1 release, 0 off |

## Verification
Some rules hold on every cycle, and the assertions check those: the state reached after each key edge, and the move from attack to decay at zero. They also check that the attenuation never rises during attack and never falls during sustain, that decay only stays or moves to sustain, and that off and the output saturation behave as required. The bench scenarios cover the rules that need counted time or exact values. These are the 192-clock tick spacing, the step sizes and update spacing chosen by key scaling, the first exponential attack steps, the exact sustain threshold, and the freeze at rate zero.

// File: rtl/fm_env_pkg.sv
package fm_env_pkg;
  typedef enum logic [2:0] {
    ENV_OFF = 3'd0,
    ENV_REL = 3'd1,
    ENV_SUS = 3'd2,
    ENV_DEC = 3'd3,
    ENV_ATK = 3'd4
  } env_state_e;

  localparam int ENV_W  = 10;
  localparam int RATE_W = 5;
  localparam int KC_W   = 5;
  localparam int EFF_W  = 6;
  localparam int CNT_W  = 12;
  localparam int SL_W   = 4;
  localparam int TL_W   = 7;
endpackage

// File: rtl/fm_env_tick.sv
module fm_env_tick #(
  parameter int DIV_A = 64,
  parameter int DIV_B = 3,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int AW = (DIV_A > 1) ? $clog2(DIV_A) : 1;
  localparam int BW = (DIV_B > 1) ? $clog2(DIV_B) : 1;

  logic [AW-1:0]    a_q, a_n;
  logic [BW-1:0]    b_q, b_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             wrap_a, wrap_b;

  always_comb begin
    wrap_a = (a_q == AW'(DIV_A - 1));
    wrap_b = (b_q == BW'(DIV_B - 1));
    a_n    = wrap_a ? '0 : a_q + AW'(1);
    b_n    = b_q;
    if (wrap_a) b_n = wrap_b ? '0 : b_q + BW'(1);
    tick_o = wrap_a && wrap_b;
    cnt_n  = tick_o ? cnt_q + CNT_W'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      cnt_q <= '0;
    end else begin
      a_q   <= a_n;
      b_q   <= b_n;
      cnt_q <= cnt_n;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fm_env_rate.sv
module fm_env_rate #(
  parameter int RATE_W = 5,
  parameter int KC_W   = 5,
  parameter int EFF_W  = 6
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic [KC_W-1:0]   kcode_i,
  input  logic [1:0]        ksr_i,
  output logic [EFF_W-1:0]  eff_o
);
  localparam int SW = ((RATE_W + 1) > KC_W ? (RATE_W + 1) : KC_W) + 1;
  localparam logic [SW-1:0] EFF_MAX = SW'((1 << EFF_W) - 1);

  logic [KC_W-1:0] ks;
  logic [SW-1:0]   sum;

  always_comb begin
    ks  = kcode_i >> (2'd3 - ksr_i);
    sum = SW'({rate_i, 1'b0}) + SW'(ks);
    if (rate_i == '0)       eff_o = '0;
    else if (sum > EFF_MAX) eff_o = EFF_MAX[EFF_W-1:0];
    else                    eff_o = sum[EFF_W-1:0];
  end
endmodule

// File: rtl/fm_env_step.sv
module fm_env_step #(
  parameter int EFF_W = 6,
  parameter int CNT_W = 12
) (
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [EFF_W-1:0] eff_i,
  output logic             upd_o,
  output logic [2:0]       step_sh_o,
  output logic             fast_o
);
  localparam int HW       = EFF_W - 2;
  localparam int SLOW_TOP = 11;
  localparam int FAST_MIN = 62;

  logic [HW-1:0]    hi;
  logic [3:0]       shift;
  logic [CNT_W-1:0] mask;
  int               hv;

  always_comb begin
    hi        = eff_i[EFF_W-1:2];
    hv        = int'(hi);
    shift     = (hv < SLOW_TOP) ? 4'(SLOW_TOP - hv) : 4'd0;
    step_sh_o = (hv > SLOW_TOP) ? 3'(hv - SLOW_TOP) : 3'd0;
    mask      = (CNT_W'(1) << shift) - CNT_W'(1);
    upd_o     = tick_i && (eff_i != '0) && ((cnt_i & mask) == '0);
    fast_o    = (int'(eff_i) >= FAST_MIN);
  end
endmodule

// File: rtl/fm_env_gen.sv
module fm_env_gen
  import fm_env_pkg::*;
#(
  parameter int DIV_A = 64,
  parameter int DIV_B = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_i,
  input  logic [RATE_W-1:0] atk_rate_i,
  input  logic [RATE_W-1:0] dec1_rate_i,
  input  logic [RATE_W-1:0] dec2_rate_i,
  input  logic [RATE_W-1:0] rel_rate_i,
  input  logic [SL_W-1:0]   sus_lvl_i,
  input  logic [TL_W-1:0]   tot_lvl_i,
  input  logic [1:0]        ksr_i,
  input  logic [KC_W-1:0]   kcode_i,
  output logic [ENV_W-1:0]  level_o,
  output logic [2:0]        state_o
);
  localparam logic [ENV_W-1:0] ENV_MAX = '1;
  localparam int DW = ENV_W + 5;
  localparam int SL_SH = ENV_W - SL_W - 1;

  env_state_e        st_q, st_n;
  logic [ENV_W-1:0]  at_q, at_n;
  logic              key_q;
  logic              key_rise, key_fall;

  logic              tick;
  logic [CNT_W-1:0]  tcnt;
  logic [RATE_W-1:0] rate_sel;
  logic [EFF_W-1:0]  eff;
  logic              upd, fast;
  logic [2:0]        sh;

  logic [ENV_W-1:0]  chunk, atk_next, up_next, thr;
  logic [DW-1:0]     dec_amt;
  logic [ENV_W:0]    up_sum;
  logic [ENV_W:0]    lvl_sum;

  fm_env_tick #(.DIV_A(DIV_A), .DIV_B(DIV_B), .CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick), .cnt_o(tcnt)
  );

  fm_env_rate #(.RATE_W(RATE_W), .KC_W(KC_W), .EFF_W(EFF_W)) u_rate (
    .rate_i(rate_sel), .kcode_i(kcode_i), .ksr_i(ksr_i), .eff_o(eff)
  );

  fm_env_step #(.EFF_W(EFF_W), .CNT_W(CNT_W)) u_step (
    .tick_i(tick), .cnt_i(tcnt), .eff_i(eff),
    .upd_o(upd), .step_sh_o(sh), .fast_o(fast)
  );

  assign key_rise = key_i & ~key_q;
  assign key_fall = ~key_i & key_q;

  // rate used for the current phase; a starting attack uses the attack rate
  always_comb begin
    if (key_rise) rate_sel = atk_rate_i;
    else begin
      unique case (st_q)
        ENV_ATK: rate_sel = atk_rate_i;
        ENV_DEC: rate_sel = dec1_rate_i;
        ENV_SUS: rate_sel = dec2_rate_i;
        ENV_REL: rate_sel = rel_rate_i;
        default: rate_sel = '0;
      endcase
    end
  end

  // arithmetic for the two directions of travel
  always_comb begin
    chunk    = ENV_W'(at_q >> 4) + ENV_W'(1);
    dec_amt  = DW'(chunk) << sh;
    atk_next = (dec_amt >= DW'(at_q)) ? '0 : ENV_W'(DW'(at_q) - dec_amt);
    up_sum   = (ENV_W+1)'(at_q) + ((ENV_W+1)'(1) << sh);
    up_next  = (up_sum > (ENV_W+1)'(ENV_MAX)) ? ENV_MAX : up_sum[ENV_W-1:0];
    thr      = (sus_lvl_i == '1) ? ENV_MAX : (ENV_W'(sus_lvl_i) << SL_SH);
  end

  always_comb begin
    st_n = st_q;
    at_n = at_q;
    if (key_rise) begin
      st_n = ENV_ATK;
      if (fast) at_n = '0;
    end else if (key_fall && st_q != ENV_OFF) begin
      st_n = ENV_REL;
    end else begin
      unique case (st_q)
        ENV_ATK: begin
          if (at_q == '0)  st_n = ENV_DEC;
          else if (fast)   at_n = '0;
          else if (upd)    at_n = atk_next;
        end
        ENV_DEC: begin
          if (at_q >= thr) st_n = ENV_SUS;
          else if (upd)    at_n = up_next;
        end
        ENV_SUS: begin
          if (upd)         at_n = up_next;
        end
        ENV_REL: begin
          if (at_q == ENV_MAX) st_n = ENV_OFF;
          else if (upd)        at_n = up_next;
        end
        default: at_n = ENV_MAX;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENV_OFF;
      at_q  <= ENV_MAX;
      key_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      at_q  <= at_n;
      key_q <= key_i;
    end
  end

  always_comb begin
    lvl_sum = (ENV_W+1)'(at_q) + (ENV_W+1)'({tot_lvl_i, 3'b000});
    level_o = lvl_sum[ENV_W] ? ENV_MAX : lvl_sum[ENV_W-1:0];
  end

  assign state_o = st_q;
endmodule

// File: rtl/fm_env_gen_chk.sv
module fm_env_gen_chk #(
  parameter int ENV_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_i,
  input logic [2:0]       state_i,
  input logic [ENV_W-1:0] atten_i,
  input logic [ENV_W-1:0] level_i
);
  localparam logic [2:0] S_OFF = 3'd0, S_REL = 3'd1, S_SUS = 3'd2, S_DEC = 3'd3, S_ATK = 3'd4;
  localparam logic [ENV_W-1:0] FULL = '1;

  a_r2_rise_attacks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_i) |=> state_i == S_ATK);

  a_r3_fall_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(key_i) && state_i != S_OFF) |=> state_i == S_REL);

  a_r6_attack_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == S_ATK && key_i) |=> atten_i <= $past(atten_i));

  a_r7_attack_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == S_ATK && atten_i == '0 && key_i) |=> state_i == S_DEC);

  a_r8_decay_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == S_DEC && key_i) |=> (state_i == S_DEC || state_i == S_SUS));

  a_r9_sustain_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == S_SUS && key_i) |=> (state_i == S_SUS && atten_i >= $past(atten_i)));

  a_r10_off_full: assert property (@(posedge clk) disable iff (!rst_n)
    state_i == S_OFF |-> (atten_i == FULL && level_i == FULL));

  a_r11_level_floor: assert property (@(posedge clk) disable iff (!rst_n)
    level_i >= atten_i);
endmodule

bind fm_env_gen fm_env_gen_chk #(.ENV_W(fm_env_pkg::ENV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_i(key_i),
  .state_i(st_q), .atten_i(at_q), .level_i(level_o)
);

// File: tb/fm_env_gen_test.sv
module fm_env_gen_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, key;
  logic [4:0] ar, d1r, d2r, rr, kc;
  logic [3:0] sl;
  logic [6:0] tl;
  logic [1:0] ksr;
  logic [9:0] level;
  logic [2:0] state;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  fm_env_gen uut (
    .clk(clk), .rst_n(rst_n), .key_i(key),
    .atk_rate_i(ar), .dec1_rate_i(d1r), .dec2_rate_i(d2r), .rel_rate_i(rr),
    .sus_lvl_i(sl), .tot_lvl_i(tl), .ksr_i(ksr), .kcode_i(kc),
    .level_o(level), .state_o(state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input int s, input int limit);
    int c = 0;
    while (int'(state) != s && c < limit) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic wait_change(input int limit, output int c, output int val);
    int old = int'(level);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (int'(level) == old && c < limit);
    val = int'(level);
  endtask

  task automatic go_off();
    key = 1'b0;
    rr  = 5'd31;
    wait_state(0, 30000);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; key = 1'b0;
    ar = 5'd31; d1r = 5'd31; d2r = 5'd0; rr = 5'd31;
    sl = 4'd4; tl = 7'd0; ksr = 2'd0; kc = 5'd0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(state == 3'd0, "R1 state", state, 0);
    chk(level == 10'd1023, "R1 level", level, 1023);
  endtask

  task automatic t_fast_path();
    int c, v, p;
    key = 1'b1;
    cyc(1);
    chk(state == 3'd4, "R2 attack entry", state, 4);
    chk(level == 10'd0, "R6 instant attack", level, 0);
    cyc(1);
    chk(state == 3'd3, "R7 to decay", state, 3);
    wait_change(400, c, v);
    chk(v == 16, "R8 first decay step", v, 16);
    p = v;
    wait_change(400, c, v);
    chk(c == 192, "R5 tick spacing", c, 192);
    chk(v - p == 16, "R5 step size", v - p, 16);
    wait_state(2, 3000);
    chk(state == 3'd2, "R8 sustain reached", state, 2);
    chk(level == 10'd128, "R8 threshold", level, 128);
    cyc(2000);
    chk(level == 10'd128, "R4 rate zero freezes", level, 128);
    chk(state == 3'd2, "R2 held key no retrigger", state, 2);
  endtask

  task automatic t_total_level();
    tl = 7'd10;
    cyc(1);
    chk(level == 10'd208, "R11 add", level, 208);
    tl = 7'd127;
    cyc(1);
    chk(level == 10'd1023, "R11 saturate", level, 1023);
    tl = 7'd0;
    cyc(1);
  endtask

  task automatic t_release();
    key = 1'b0;
    cyc(1);
    chk(state == 3'd1, "R3 release entry", state, 1);
    wait_state(0, 20000);
    chk(state == 3'd0, "R10 off reached", state, 0);
    chk(level == 10'd1023, "R10 off level", level, 1023);
    cyc(500);
    chk(state == 3'd0 && level == 10'd1023, "R3 low key in off ignored", level, 1023);
  endtask

  task automatic t_sustain_climb();
    int c = 0;
    d2r = 5'd31;
    key = 1'b1;
    wait_state(2, 3000);
    while (level != 10'd1023 && c < 30000) begin
      @(negedge clk);
      c++;
    end
    cyc(1000);
    chk(state == 3'd2, "R9 stays sustain", state, 2);
    chk(level == 10'd1023, "R9 saturates", level, 1023);
    d2r = 5'd0;
    go_off();
  endtask

  task automatic t_key_scale();
    int c, v, p;
    d1r = 5'd20; sl = 4'd15; kc = 5'd31; ksr = 2'd0;
    key = 1'b1;
    wait_state(3, 100);
    wait_change(1000, c, p);
    wait_change(1000, c, v);
    chk(c == 384, "R4 ksr0 update spacing", c, 384);
    chk(v - p == 1, "R5 slow step", v - p, 1);
    ksr = 2'd3;
    wait_change(1000, c, p);
    wait_change(1000, c, v);
    chk(c == 192, "R4 ksr3 update spacing", c, 192);
    chk(v - p == 16, "R4 clamped rate step", v - p, 16);
    chk(state == 3'd3, "R8 below threshold stays decay", state, 3);
    go_off();
  endtask

  task automatic t_slow_attack();
    int c, v, e;
    ar = 5'd20; kc = 5'd31; ksr = 2'd1; d1r = 5'd0;
    key = 1'b1;
    cyc(1);
    chk(state == 3'd4, "R2 attack entry", state, 4);
    chk(level == 10'd1023, "R6 no instant jump", level, 1023);
    wait_change(400, c, v);
    chk(v == 959, "R6 first attack step", v, 959);
    e = 959 - ((959 >> 4) + 1);
    wait_change(400, c, v);
    chk(v == e, "R6 second attack step", v, e);
    chk(c == 192, "R5 attack spacing", c, 192);
    key = 1'b0;
    cyc(1);
    chk(state == 3'd1, "R3 release from attack", state, 1);
    go_off();
  endtask

  initial begin
    t_reset();
    t_fast_path();
    t_total_level();
    t_release();
    t_sustain_climb();
    t_key_scale();
    t_slow_attack();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(190000 * 10);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule